// File: doc/BRIEF.md
# Privileged Exception Entry Sequencer

This block drives the control-flow changes of a simple in-order core when an exception is taken and when privileged code returns from one. Each cycle it looks at a qualified fault code, the PC of the instruction in flight and a programmable vector base. On an accepted exception it computes the handler address, saves a restart address and decides whether the core's bank of shadow integer registers has to be brought in. On a return request it jumps back to the saved address and leaves the shadow bank when the saved address says so.

Bit 0 of every PC marks privileged mode. All handler offsets carry that bit, so a jump to a handler lands in privileged mode. A return request made outside privileged mode is illegal and is turned into an unimplemented-opcode exception. The shadow bank state is given both as a level and as a one-cycle toggle pulse, so a register file can remap integer registers 8 to 14 and 25. All outputs are registered, so results appear one clock after the inputs are sampled. Reset is synchronous and active high.

Top module: `exc_seq_top`

## Requirements
- R1: While reset is high and on the first cycle after it, the PC output is the vector base plus 0x0001, the next-PC output is that value plus 4, the bank level is 1, the saved address is 0 and the load, toggle, error and illegal-return pulses are 0.
- R2: An accepted exception sets the PC output to the vector base plus the offset of its code. The codes and offsets are: 1 reset 0x0001, 2 machine check 0x0401, 3 arithmetic 0x0501, 4 interrupt 0x0101, 5 data-TLB miss from native code 0x0201, 6 data-TLB miss from privileged code 0x0281, 7 alignment 0x0301, 8 data-TLB fault 0x0381, 9 data-TLB access violation 0x0381, 10 instruction-TLB miss 0x0181, 11 instruction-TLB fault 0x0181, 12 instruction-TLB access violation 0x0081, 13 unimplemented opcode 0x0481, 14 FP disabled 0x0581, 15 PAL call 0x2001, 16 integer overflow 0x0501.
- R3: Every exception entry and every return raises the load pulse for one cycle with the next-PC output equal to the PC output plus 4; after an entry, bit 0 of the PC output is 1.
- R4: On entry the saved address becomes the current PC plus 4 for codes 3, 15 and 16 (traps), and the current PC itself for every other code.
- R5: An interrupt (code 4) taken while bit 0 of the current PC is 1 leaves the saved address unchanged.
- R6: An entry with bit 0 of the current PC equal to 0 sets the bank level to 1 and pulses the toggle output for one cycle; an entry from privileged code changes neither.
- R7: A return request with bit 0 of the current PC equal to 1 loads the saved address into the PC output. When bit 0 of the saved address is 0, it also sets the bank level to 0 and pulses the toggle; otherwise the bank stays unchanged.
- R8: A return request with bit 0 of the current PC equal to 0 is taken as an unimplemented-opcode entry (offset 0x0481, saved address = current PC), and the illegal-return output pulses for one cycle.
- R9: When an accepted exception and a return request arrive in the same cycle, only the exception is taken.
- R10: A swap into the bank state that is already active raises the swap-error pulse for one cycle, leaves the bank level unchanged and gives no toggle pulse.
- R11: A valid strobe with code 0 or a code above 16 is ignored: no load pulse, and the saved address and bank level stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| exc_valid | input | 1 | Qualifies exc_code for one cycle |
| exc_code | input | 5 | Fault code |
| cur_pc | input | PC_W | PC of the instruction in flight; bit 0 marks privileged mode |
| vec_base | input | PC_W | Programmable handler base |
| ret_req | input | 1 | Return-from-exception request |
| pc_load | output | 1 | New PC is valid this cycle |
| pc_out | output | PC_W | New PC |
| npc_out | output | PC_W | New next PC |
| saved_addr | output | PC_W | Saved restart address |
| bank_sel | output | 1 | Shadow bank active level |
| bank_toggle | output | 1 | One-cycle pulse on each bank switch |
| swap_err | output | 1 | Swap into an already active bank state |
| ret_illegal | output | 1 | Return request made outside privileged mode |

## Verification
The assertions assume that reset is held long enough for the inputs to be idle on the first cycle after it, that vec_base is stable and has its low bits clear below the largest offset, and that cur_pc reflects the PC the core has actually reached. The bench walks the core through a consistent sequence: it leaves privileged mode only through a legal return and keeps cur_pc equal to the last PC the block produced, or to a plain native address after a return. The one deliberate departure is a native-mode entry while the bank is still active, used to provoke the swap error.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  localparam int CODE_W = 5;
  localparam int OFS_W  = 14;

  typedef enum logic [CODE_W-1:0] {
    FC_NONE        = 5'd0,
    FC_RESET       = 5'd1,
    FC_MCHK        = 5'd2,
    FC_ARITH       = 5'd3,
    FC_INTR        = 5'd4,
    FC_DTLB_MISS_N = 5'd5,
    FC_DTLB_MISS_P = 5'd6,
    FC_ALIGN       = 5'd7,
    FC_DTLB_FAULT  = 5'd8,
    FC_DTLB_ACV    = 5'd9,
    FC_ITLB_MISS   = 5'd10,
    FC_ITLB_FAULT  = 5'd11,
    FC_ITLB_ACV    = 5'd12,
    FC_UNIMP       = 5'd13,
    FC_FPEN        = 5'd14,
    FC_PALCALL     = 5'd15,
    FC_IOVF        = 5'd16
  } fault_e;

  localparam logic [CODE_W-1:0] FC_MAX = 5'd16;
  localparam logic [OFS_W-1:0]  RESET_OFS = 14'h0001;
endpackage

// File: rtl/exc_vec_rom.sv
module exc_vec_rom
  import exc_seq_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output logic [OFS_W-1:0]  ofs,
  output logic              known
);
  always_comb begin
    known = (code != FC_NONE) && (code <= FC_MAX);
    unique case (code)
      FC_RESET:                      ofs = 14'h0001;
      FC_ITLB_ACV:                   ofs = 14'h0081;
      FC_INTR:                       ofs = 14'h0101;
      FC_ITLB_MISS, FC_ITLB_FAULT:   ofs = 14'h0181;
      FC_DTLB_MISS_N:                ofs = 14'h0201;
      FC_DTLB_MISS_P:                ofs = 14'h0281;
      FC_ALIGN:                      ofs = 14'h0301;
      FC_DTLB_FAULT, FC_DTLB_ACV:    ofs = 14'h0381;
      FC_MCHK:                       ofs = 14'h0401;
      FC_UNIMP:                      ofs = 14'h0481;
      FC_ARITH, FC_IOVF:             ofs = 14'h0501;
      FC_FPEN:                       ofs = 14'h0581;
      FC_PALCALL:                    ofs = 14'h2001;
      default:                       ofs = '0;
    endcase
  end
endmodule

// File: rtl/exc_entry_calc.sv
module exc_entry_calc
  import exc_seq_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic [CODE_W-1:0] code,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic [PC_W-1:0]   old_addr,
  output logic [PC_W-1:0]   new_addr,
  output logic              swap_in
);
  localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

  logic in_priv, is_trap, hold;

  always_comb begin
    in_priv  = cur_pc[0];
    is_trap  = (code == FC_PALCALL) || (code == FC_ARITH) || (code == FC_IOVF);
    hold     = (code == FC_INTR) && in_priv;
    swap_in  = !in_priv;
    if (hold)         new_addr = old_addr;
    else if (is_trap) new_addr = cur_pc + STEP;
    else              new_addr = cur_pc;
  end
endmodule

// File: rtl/exc_seq_top.sv
module exc_seq_top
  import exc_seq_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exc_valid,
  input  logic [4:0]        exc_code,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic [PC_W-1:0]   vec_base,
  input  logic              ret_req,
  output logic              pc_load,
  output logic [PC_W-1:0]   pc_out,
  output logic [PC_W-1:0]   npc_out,
  output logic [PC_W-1:0]   saved_addr,
  output logic              bank_sel,
  output logic              bank_toggle,
  output logic              swap_err,
  output logic              ret_illegal
);
  localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

  logic [CODE_W-1:0] eff_code;
  logic [OFS_W-1:0]  vec_ofs;
  logic              code_known, accept, ret_ok, ret_bad, enter, swap_in;
  logic [PC_W-1:0]   entry_addr, target;

  exc_vec_rom u_rom (
    .code  (eff_code),
    .ofs   (vec_ofs),
    .known (code_known)
  );

  exc_entry_calc #(.PC_W(PC_W), .INSN_BYTES(INSN_BYTES)) u_calc (
    .code     (eff_code),
    .cur_pc   (cur_pc),
    .old_addr (saved_addr),
    .new_addr (entry_addr),
    .swap_in  (swap_in)
  );

  always_comb begin
    accept   = exc_valid && (exc_code != FC_NONE) && (exc_code <= FC_MAX);
    ret_ok   = ret_req && !accept && cur_pc[0];
    ret_bad  = ret_req && !accept && !cur_pc[0];
    enter    = accept || ret_bad;
    eff_code = accept ? exc_code : FC_UNIMP;
    target   = vec_base + {{(PC_W-OFS_W){1'b0}}, vec_ofs};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_out      <= vec_base + {{(PC_W-OFS_W){1'b0}}, RESET_OFS};
      npc_out     <= vec_base + {{(PC_W-OFS_W){1'b0}}, RESET_OFS} + STEP;
      saved_addr  <= '0;
      bank_sel    <= 1'b1;
      pc_load     <= 1'b0;
      bank_toggle <= 1'b0;
      swap_err    <= 1'b0;
      ret_illegal <= 1'b0;
    end else begin
      pc_load     <= 1'b0;
      bank_toggle <= 1'b0;
      swap_err    <= 1'b0;
      ret_illegal <= 1'b0;
      if (enter && code_known) begin
        pc_out      <= target;
        npc_out     <= target + STEP;
        saved_addr  <= entry_addr;
        pc_load     <= 1'b1;
        ret_illegal <= ret_bad;
        if (swap_in) begin
          if (bank_sel) swap_err <= 1'b1;
          else begin
            bank_sel    <= 1'b1;
            bank_toggle <= 1'b1;
          end
        end
      end else if (ret_ok) begin
        pc_out  <= saved_addr;
        npc_out <= saved_addr + STEP;
        pc_load <= 1'b1;
        if (!saved_addr[0]) begin
          if (!bank_sel) swap_err <= 1'b1;
          else begin
            bank_sel    <= 1'b0;
            bank_toggle <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            exc_valid,
  input logic [4:0]      exc_code,
  input logic [PC_W-1:0] cur_pc,
  input logic [PC_W-1:0] vec_base,
  input logic            ret_req,
  input logic            pc_load,
  input logic [PC_W-1:0] pc_out,
  input logic [PC_W-1:0] npc_out,
  input logic [PC_W-1:0] saved_addr,
  input logic            bank_sel,
  input logic            bank_toggle,
  input logic            swap_err,
  input logic            ret_illegal
);
  logic ok_code;
  assign ok_code = exc_valid && (exc_code != 5'd0) && (exc_code <= 5'd16);

  // R6
  bank_in_chk: assert property (@(posedge clk) disable iff (rst)
    (ok_code && !cur_pc[0]) |=> bank_sel);

  // R3
  entry_priv_chk: assert property (@(posedge clk) disable iff (rst)
    ok_code |=> (pc_load && pc_out[0]));

  // R3
  npc_step_chk: assert property (@(posedge clk) disable iff (rst)
    pc_load |-> (npc_out == pc_out + PC_W'(4)));

  // R5
  intr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ok_code && exc_code == 5'd4 && cur_pc[0]) |=> $stable(saved_addr));

  // R7
  ret_jump_chk: assert property (@(posedge clk) disable iff (rst)
    (ret_req && !ok_code && cur_pc[0]) |=> (pc_out == $past(saved_addr)));

  // R8
  ret_bad_chk: assert property (@(posedge clk) disable iff (rst)
    (ret_req && !ok_code && !cur_pc[0]) |=>
      (ret_illegal && pc_out == $past(vec_base) + PC_W'(32'h481)));

  // R10
  swap_err_chk: assert property (@(posedge clk) disable iff (rst)
    swap_err |-> (!bank_toggle && $stable(bank_sel)));

  // R11
  ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (exc_valid && !ok_code && !ret_req) |=>
      (!pc_load && $stable(saved_addr) && $stable(bank_sel)));
endmodule

bind exc_seq_top exc_seq_chk #(.PC_W(PC_W)) u_exc_seq_chk (.*);

// File: tb/test_exc_seq_top.sv
module test_exc_seq_top;
  localparam int PC_W = 32;
  localparam logic [31:0] BASE = 32'h0010_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic exc_valid = 1'b0;
  logic [4:0] exc_code = '0;
  logic [PC_W-1:0] cur_pc = '0;
  logic [PC_W-1:0] vec_base = BASE;
  logic ret_req = 1'b0;
  logic pc_load, bank_sel, bank_toggle, swap_err, ret_illegal;
  logic [PC_W-1:0] pc_out, npc_out, saved_addr;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  exc_seq_top #(.PC_W(PC_W)) i_exc_seq_top (
    .clk(clk), .rst(rst), .exc_valid(exc_valid), .exc_code(exc_code),
    .cur_pc(cur_pc), .vec_base(vec_base), .ret_req(ret_req),
    .pc_load(pc_load), .pc_out(pc_out), .npc_out(npc_out),
    .saved_addr(saved_addr), .bank_sel(bank_sel), .bank_toggle(bank_toggle),
    .swap_err(swap_err), .ret_illegal(ret_illegal)
  );

  function automatic logic [31:0] ofs_of(input int c);
    case (c)
      1: return 32'h0001;  2: return 32'h0401;  3: return 32'h0501;
      4: return 32'h0101;  5: return 32'h0201;  6: return 32'h0281;
      7: return 32'h0301;  8: return 32'h0381;  9: return 32'h0381;
      10: return 32'h0181; 11: return 32'h0181; 12: return 32'h0081;
      13: return 32'h0481; 14: return 32'h0581; 15: return 32'h2001;
      16: return 32'h0501;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, let one posedge pass, sample at following negedge
  task automatic step(input logic v, input int code, input logic [31:0] pc, input logic r);
    exc_valid = v; exc_code = 5'(code); cur_pc = pc; ret_req = r;
    @(posedge clk); @(negedge clk);
    exc_valid = 1'b0; ret_req = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 pc", pc_out, BASE + 32'h1);
    chk("R1 npc", npc_out, BASE + 32'h5);
    chk("R1 bank", 32'(bank_sel), 32'd1);
    chk("R1 saved", saved_addr, 32'h0);
    chk("R1 pulses", {28'd0, pc_load, bank_toggle, swap_err, ret_illegal}, 32'h0);
  endtask

  task automatic t_ret_even(input logic [31:0] from_pc, input logic [31:0] exp_pc);
    step(1'b0, 0, from_pc, 1'b1);
    chk("R7 pc", pc_out, exp_pc);
    chk("R7 npc", npc_out, exp_pc + 4);
    chk("R7 load", 32'(pc_load), 32'd1);
    chk("R7 bank out", {bank_sel, bank_toggle}, 2'b01);
  endtask

  task automatic t_user_fault();
    step(1'b1, 5, 32'h1000, 1'b0);
    chk("R2 dtlb miss vec", pc_out, BASE + 32'h201);
    chk("R4 fault saves pc", saved_addr, 32'h1000);
    chk("R6 bank in", {bank_sel, bank_toggle}, 2'b11);
    chk("R3 priv bit", 32'(pc_out[0]), 32'd1);
  endtask

  task automatic t_priv_intr();
    step(1'b1, 4, BASE + 32'h201, 1'b0);
    chk("R5 saved held", saved_addr, 32'h1000);
    chk("R2 intr vec", pc_out, BASE + 32'h101);
    chk("R6 no toggle priv", {bank_sel, bank_toggle}, 2'b10);
  endtask

  task automatic t_priv_fault();
    step(1'b1, 7, BASE + 32'h101, 1'b0);
    chk("R4 priv fault saves pc", saved_addr, BASE + 32'h101);
    chk("R2 align vec", pc_out, BASE + 32'h301);
  endtask

  task automatic t_ret_odd();
    step(1'b0, 0, BASE + 32'h301, 1'b1);
    chk("R7 odd target", pc_out, BASE + 32'h101);
    chk("R7 bank kept", {bank_sel, bank_toggle}, 2'b10);
  endtask

  task automatic t_swap_err();
    step(1'b1, 13, 32'h4000, 1'b0);
    chk("R10 err", 32'(swap_err), 32'd1);
    chk("R10 bank", {bank_sel, bank_toggle}, 2'b10);
    chk("R10 saved", saved_addr, 32'h4000);
  endtask

  task automatic t_trap(input int code, input logic [31:0] from_pc);
    step(1'b1, code, from_pc, 1'b0);
    chk("R4 trap skip", saved_addr, from_pc + 4);
    chk("R2 trap vec", pc_out, BASE + ofs_of(code));
    chk("R6 trap bank in", {bank_sel, bank_toggle}, 2'b11);
  endtask

  task automatic t_ret_illegal();
    step(1'b0, 0, 32'h6000, 1'b1);
    chk("R8 flag", 32'(ret_illegal), 32'd1);
    chk("R8 vec", pc_out, BASE + 32'h481);
    chk("R8 saved", saved_addr, 32'h6000);
    chk("R8 bank", {bank_sel, bank_toggle}, 2'b11);
  endtask

  task automatic t_priority();
    step(1'b1, 2, BASE + 32'h481, 1'b1);
    chk("R9 exc wins", pc_out, BASE + 32'h401);
    chk("R9 saved", saved_addr, BASE + 32'h481);
  endtask

  task automatic t_ignore();
    step(1'b1, 0, BASE + 32'h401, 1'b0);
    chk("R11 code0 no load", 32'(pc_load), 32'd0);
    step(1'b1, 20, BASE + 32'h401, 1'b0);
    chk("R11 code20 no load", 32'(pc_load), 32'd0);
    chk("R11 saved kept", saved_addr, BASE + 32'h481);
    chk("R11 bank kept", 32'(bank_sel), 32'd1);
  endtask

  task automatic t_sweep();
    for (int c = 1; c <= 16; c++) begin
      step(1'b1, c, BASE + 32'h1, 1'b0);
      chk("R2 sweep", pc_out, BASE + ofs_of(c));
      chk("R3 sweep npc", npc_out, BASE + ofs_of(c) + 4);
    end
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ret_even(BASE + 32'h1, 32'h0);
        t_user_fault();
        t_priv_intr();
        t_priv_fault();
        t_ret_odd();
        t_swap_err();
        t_ret_even(BASE + 32'h481, 32'h4000);
        t_trap(15, 32'h5000);
        t_ret_even(BASE + 32'h2001, 32'h5004);
        t_trap(16, 32'h7000);
        t_ret_even(BASE + 32'h501, 32'h7004);
        t_trap(3, 32'h8000);
        t_ret_even(BASE + 32'h501, 32'h8004);
        t_ret_illegal();
        t_priority();
        t_ignore();
        t_sweep();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule